// File: doc/BRIEF.md
# Power-Management I2C Single-Write Command Engine

This block lets software update one register in an external power-management device through a dedicated I2C master. Software loads a command word that holds a 7-bit target address, an 8-bit register address and an 8-bit data byte. Setting the start flag in the same write launches the transfer. The engine then sends the frame on its own: START, the address byte with the write bit, the register byte, the data byte, and STOP. It checks for an acknowledge after every byte. When the frame ends, the hardware clears the start flag, so software only has to poll that bit until it reads zero.

A second word sets the SCL high and low counts in system clocks. The engine adds fixed offsets to these counts. The intent is a period split of about 40% high and 60% low, at a bus rate of no more than 400 kHz. A mode word is stored and can be read back, but it does not change how a transfer runs. Both bus lines are open-drain: the block only ever pulls a line low or releases it.

If the device does not acknowledge a byte, the engine ends the frame with STOP and sets a sticky error bit. That bit stays set until the next transfer is launched.

Top module: `pwr_i2c_cmd_engine`

## Requirements
- R1: Register index 0 holds the command word: target address in bits [6:0], register address in bits [15:8], data in bits [23:16], start flag at bit 24, sticky error at bit 25 (read only). Bit 7 and bits [31:26] read as 0.
- R2: A write to index 0 with bit 24 set while the engine is idle starts a transfer, and `busy` rises on the same clock edge. Bit 24 and `busy` stay 1 until the frame ends, then the hardware clears both. A write with bit 24 clear updates the fields and starts nothing.
- R3: A frame is START, then the byte {target, 0}, then the register byte, then the data byte, each sent MSB first and each followed by one acknowledge clock, then STOP. SCL and SDA are both released when a transfer begins.
- R4: Register index 1 is the clock word: SCL high count in bits [7:0] and SCL low count in bits [15:8]. Every SCL high phase of a bit lasts high count + 5 clocks, and every SCL low phase lasts low count + 7 clocks. Bits [31:16] are stored and read back, and have no effect.
- R5: During a frame, SDA changes only while SCL is low. The exceptions are START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high), and each occurs exactly once per frame.
- R6: SDA is sampled in the last clock of the high phase of each acknowledge clock. A high level (NACK) makes the engine send STOP straight after that clock, clear bit 24 and set the error bit. The error bit stays 1 until the next accepted start.
- R7: A write to index 0 while bit 24 is 1 is ignored: the fields, the start flag and the frame in progress are all unchanged.
- R8: Register index 2 is the mode word. Only bits [1:0], 3, 4 and 6 are kept and all other bits read 0. Its contents do not change the frame or its timing. Index 3 reads 0.
- R9: After reset, SCL and SDA are released, `busy` is 0, the command word reads 0, the mode word reads 0, and the clock word reads the parameter defaults (0x0000190F).
- R10: With H = high count + 5 and L = low count + 7, `busy` stays high for H + 9·n·(L + H) + L + H clocks. Here n is 3 for a fully acknowledged frame, or b + 1 when byte b (counting from 0) is NACKed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data of the register at `reg_idx` |
| busy | output | 1 | Transfer in progress (mirror of the start flag) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Level of the SDA line |

## Verification
Read data is combinational, so the bench reads a register in the same cycle it sets the index. `busy` is already high at the first falling edge after the write edge. The bench then counts the falling edges while `busy` stays high and compares that count with the R10 formula for the chosen counts and NACK position. Phase lengths are measured edge to edge on the sampled SCL line and must equal H and L exactly. The error bit and the cleared start flag are read a few cycles after `busy` falls, which gives the STOP edge (one clock after idle) time to be seen by the bench's bus monitor.

// File: rtl/pwr_i2c_pkg.sv
package pwr_i2c_pkg;

  localparam int CNT_W     = 8;          // width of a programmed SCL phase count
  localparam int LEN_W     = CNT_W + 1;  // width of a phase length incl. offset
  localparam int HI_EXTRA  = 5;          // fixed extra clocks in every high phase
  localparam int LO_EXTRA  = 7;          // fixed extra clocks in every low phase
  localparam int NUM_BYTES = 3;          // address, register, data
  localparam int ACK_SLOT  = 8;          // bit index of the acknowledge clock
  localparam int BIT_W     = $clog2(ACK_SLOT + 1);
  localparam int BYTE_W    = $clog2(NUM_BYTES);
  localparam int START_BIT = 24;         // start flag position in the command word
  localparam logic [31:0] MODE_KEEP = 32'h0000_005B;

  typedef logic [LEN_W-1:0] len_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT_L,
    ST_BIT_H,
    ST_STOP_L,
    ST_STOP_H
  } bus_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic [7:0] reg_addr;
    logic [6:0] target;
  } cmd_t;

  function automatic len_t high_len(input logic [CNT_W-1:0] c);
    return len_t'(c) + len_t'(HI_EXTRA);
  endfunction

  function automatic len_t low_len(input logic [CNT_W-1:0] c);
    return len_t'(c) + len_t'(LO_EXTRA);
  endfunction

  function automatic logic [7:0] frame_byte(input cmd_t c, input logic [BYTE_W-1:0] idx);
    case (idx)
      BYTE_W'(0): return {c.target, 1'b0};
      BYTE_W'(1): return c.reg_addr;
      default:    return c.data;
    endcase
  endfunction

endpackage

// File: rtl/pwr_i2c_sync.sv
module pwr_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= '1;
        else        ff <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= '1;
        else        ff <= {ff[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/pwr_i2c_phase_timer.sv
module pwr_i2c_phase_timer
  import pwr_i2c_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  len_t len,
  output logic phase_end
);
  len_t cnt;

  // ">=" keeps a phase finite if the count is lowered mid-phase
  assign phase_end = (cnt >= (len - len_t'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= cnt + len_t'(1);
  end
endmodule

// File: rtl/pwr_i2c_regs.sv
module pwr_i2c_regs
  import pwr_i2c_pkg::*;
#(
  parameter logic [CNT_W-1:0] RST_HI = 8'd15,
  parameter logic [CNT_W-1:0] RST_LO = 8'd25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_idx,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             done,
  input  logic             nack_evt,
  output cmd_t             cmd,
  output logic [CNT_W-1:0] hi_cnt,
  output logic [CNT_W-1:0] lo_cnt,
  output logic             valid,
  output logic             err,
  output logic             launch
);
  localparam logic [31:0] CLK_RESET = {16'h0000, RST_LO, RST_HI};

  logic [31:0] clk_word;
  logic [31:0] mode_word;
  logic        cmd_wr;

  assign cmd_wr = reg_we && (reg_idx == 2'd0) && !valid;
  assign launch = cmd_wr && reg_wdata[START_BIT];
  assign hi_cnt = clk_word[CNT_W-1:0];
  assign lo_cnt = clk_word[2*CNT_W-1:CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd       <= '0;
      valid     <= 1'b0;
      err       <= 1'b0;
      clk_word  <= CLK_RESET;
      mode_word <= '0;
    end else begin
      if (cmd_wr) begin
        cmd.target   <= reg_wdata[6:0];
        cmd.reg_addr <= reg_wdata[15:8];
        cmd.data     <= reg_wdata[23:16];
      end
      if (launch)      valid <= 1'b1;
      else if (done)   valid <= 1'b0;
      if (launch)        err <= 1'b0;
      else if (nack_evt) err <= 1'b1;
      if (reg_we && reg_idx == 2'd1) clk_word  <= reg_wdata;
      if (reg_we && reg_idx == 2'd2) mode_word <= reg_wdata & MODE_KEEP;
    end
  end

  always_comb begin
    case (reg_idx)
      2'd0:    reg_rdata = {6'b0, err, valid, cmd.data, cmd.reg_addr, 1'b0, cmd.target};
      2'd1:    reg_rdata = clk_word;
      2'd2:    reg_rdata = mode_word;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwr_i2c_bit_engine.sv
module pwr_i2c_bit_engine
  import pwr_i2c_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  cmd_t             cmd,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic [CNT_W-1:0] lo_cnt,
  input  logic             sda_in,
  output logic             scl_low,
  output logic             sda_low,
  output logic             done,
  output logic             nack_evt,
  output logic             in_start
);
  bus_state_e        st;
  logic [BIT_W-1:0]  bit_idx;
  logic [BYTE_W-1:0] byte_idx;
  logic [7:0]        shreg;
  logic              sda_q;
  logic              phase_end, advance, low_phase, ack_slot, last_byte, want_low;
  len_t              phase_len;

  assign low_phase = (st == ST_BIT_L) || (st == ST_STOP_L);
  assign phase_len = low_phase ? low_len(lo_cnt) : high_len(hi_cnt);
  assign advance   = phase_end && (st != ST_IDLE);
  assign ack_slot  = (bit_idx == BIT_W'(ACK_SLOT));
  assign last_byte = (byte_idx == BYTE_W'(NUM_BYTES - 1));

  pwr_i2c_phase_timer u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (launch || advance),
    .len       (phase_len),
    .phase_end (phase_end)
  );

  // events brought out for the checker
  assign nack_evt = (st == ST_BIT_H) && advance && ack_slot && sda_in;
  assign done     = (st == ST_STOP_H) && advance;
  assign in_start = (st == ST_START);

  // SDA target per state; registered one clock late so it never moves on an SCL edge
  always_comb begin
    case (st)
      ST_START, ST_STOP_L, ST_STOP_H: want_low = 1'b1;
      ST_BIT_L, ST_BIT_H:             want_low = ack_slot ? 1'b0 : !shreg[7];
      default:                        want_low = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bit_idx  <= '0;
      byte_idx <= '0;
      shreg    <= '0;
      sda_q    <= 1'b0;
    end else begin
      sda_q <= want_low;
      case (st)
        ST_IDLE:  if (launch) st <= ST_START;
        ST_START: if (advance) begin
          st       <= ST_BIT_L;
          shreg    <= frame_byte(cmd, BYTE_W'(0));
          bit_idx  <= '0;
          byte_idx <= '0;
        end
        ST_BIT_L: if (advance) st <= ST_BIT_H;
        ST_BIT_H: if (advance) begin
          if (ack_slot) begin
            if (sda_in || last_byte) begin
              st <= ST_STOP_L;
            end else begin
              st       <= ST_BIT_L;
              byte_idx <= byte_idx + BYTE_W'(1);
              shreg    <= frame_byte(cmd, byte_idx + BYTE_W'(1));
              bit_idx  <= '0;
            end
          end else begin
            st      <= ST_BIT_L;
            shreg   <= {shreg[6:0], 1'b0};
            bit_idx <= bit_idx + BIT_W'(1);
          end
        end
        ST_STOP_L: if (advance) st <= ST_STOP_H;
        ST_STOP_H: if (advance) st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  assign scl_low = low_phase;
  assign sda_low = sda_q;
endmodule

// File: rtl/pwr_i2c_cmd_engine.sv
module pwr_i2c_cmd_engine
  import pwr_i2c_pkg::*;
#(
  parameter logic [CNT_W-1:0] RST_HI      = 8'd15,
  parameter logic [CNT_W-1:0] RST_LO      = 8'd25,
  parameter int               SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_idx,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        busy,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in
);
  cmd_t             cmd_w;
  logic [CNT_W-1:0] hi_w, lo_w;
  logic             launch_w, done_w, nack_w, err_w, valid_w;
  logic             scl_low_w, sda_low_w, in_start_w, sda_sync_w;

  pwr_i2c_regs #(.RST_HI(RST_HI), .RST_LO(RST_LO)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .done      (done_w),
    .nack_evt  (nack_w),
    .cmd       (cmd_w),
    .hi_cnt    (hi_w),
    .lo_cnt    (lo_w),
    .valid     (valid_w),
    .err       (err_w),
    .launch    (launch_w)
  );

  pwr_i2c_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sda_in),
    .q     (sda_sync_w)
  );

  pwr_i2c_bit_engine u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch_w),
    .cmd      (cmd_w),
    .hi_cnt   (hi_w),
    .lo_cnt   (lo_w),
    .sda_in   (sda_sync_w),
    .scl_low  (scl_low_w),
    .sda_low  (sda_low_w),
    .done     (done_w),
    .nack_evt (nack_w),
    .in_start (in_start_w)
  );

  assign busy   = valid_w;
  assign scl_oe = scl_low_w;
  assign sda_oe = sda_low_w;
endmodule

// File: rtl/pwr_i2c_cmd_engine_chk.sv
module pwr_i2c_cmd_engine_chk
  import pwr_i2c_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       scl_low,
  input logic       sda_low,
  input logic       done,
  input logic       nack_evt,
  input logic       err,
  input logic       in_start,
  input logic       reg_we,
  input logic [1:0] reg_idx,
  input cmd_t       cmd
);
  // R2: the end of a frame clears the start flag on the next edge
  a_r2_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R3: a transfer begins with SCL released
  a_r3_start_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !scl_low);

  // R5: outside START, SDA holds while SCL stays high
  a_r5_sda_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !scl_low && !$past(scl_low) && !in_start) |-> $stable(sda_low));

  // R6: a NACK sets the sticky error flag
  a_r6_nack_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt |=> err);

  // R7: command writes during a frame leave the fields untouched
  a_r7_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_idx == 2'd0 && busy) |=> $stable(cmd));

  // R9: SCL is released whenever no transfer is pending
  a_r9_idle_scl_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !scl_low);
endmodule

bind pwr_i2c_cmd_engine pwr_i2c_cmd_engine_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .scl_low  (scl_low_w),
  .sda_low  (sda_low_w),
  .done     (done_w),
  .nack_evt (nack_w),
  .err      (err_w),
  .in_start (in_start_w),
  .reg_we   (reg_we),
  .reg_idx  (reg_idx),
  .cmd      (cmd_w)
);

// File: tb/test_pwr_i2c_cmd_engine.sv
module test_pwr_i2c_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_idx;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        busy, scl_oe, sda_oe;
  logic        slave_pull;
  logic        sda_in;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign sda_in = ~(sda_oe | slave_pull);

  pwr_i2c_cmd_engine i_pwr_i2c_cmd_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  // ---------------- bus monitor and acknowledging target ----------------
  logic       prev_scl, prev_sda, s_l, d_l, h_ok;
  int         hrun, lrun, hmin, hmax, lmin, lmax, starts, stops, bitc, bytec, nack_at;
  logic [7:0] shf;
  logic [7:0] cap [3];

  always @(negedge clk) begin
    s_l = ~scl_oe;
    d_l = ~(sda_oe | slave_pull);
    if (!rst_n) begin
      prev_scl = 1'b1; prev_sda = 1'b1; slave_pull = 1'b0; h_ok = 1'b0;
      hrun = 0; lrun = 0; bitc = 0; bytec = 0;
    end else begin
      if (s_l && prev_scl && prev_sda && !d_l) begin
        starts++; bitc = 0; bytec = 0; h_ok = 1'b0;
      end
      if (s_l && prev_scl && !prev_sda && d_l) begin
        stops++; h_ok = 1'b0;
      end
      if (s_l && !prev_scl) begin
        if (lrun < lmin) lmin = lrun;
        if (lrun > lmax) lmax = lrun;
        hrun = 1; h_ok = 1'b1;
        if (bitc < 8) begin
          shf = {shf[6:0], d_l}; bitc++;
        end else begin
          if (bytec < 3) cap[bytec] = shf;
          bytec++; bitc = 0;
        end
      end else if (s_l) hrun++;
      if (!s_l && prev_scl) begin
        if (h_ok) begin
          if (hrun < hmin) hmin = hrun;
          if (hrun > hmax) hmax = hrun;
        end
        lrun = 1;
        slave_pull = (bitc == 8) && (bytec != nack_at);
      end else if (!s_l) lrun++;
      prev_scl = s_l; prev_sda = d_l;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] i, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = i; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] i, output logic [31:0] v);
    reg_idx = i;
    #1 v = reg_rdata;
  endtask

  function automatic int exp_cycles(input int hi, input int lo, input int nb);
    int h, l, cells;
    h = hi + 5;
    l = lo + 7;
    cells = ((nb >= 3) ? 3 : nb + 1) * 9;
    return h + cells * (l + h) + l + h;
  endfunction

  function automatic logic [7:0] exp_byte(input int k, input logic [6:0] sa,
                                          input logic [7:0] ra, input logic [7:0] d);
    return (k == 0) ? {sa, 1'b0} : ((k == 1) ? ra : d);
  endfunction

  task automatic run_xfer(input logic [6:0] sa, input logic [7:0] ra, input logic [7:0] d,
                          input int hi, input int lo, input int nb, input bit poke);
    logic [31:0] rd;
    int cnt, nbytes;
    reg_write(2'd1, {$urandom_range(0, 65535) & 32'hFFFF, 8'(lo), 8'(hi)});
    hmin = 1000000; hmax = 0; lmin = 1000000; lmax = 0;
    starts = 0; stops = 0; nack_at = nb;
    cap[0] = 'x; cap[1] = 'x; cap[2] = 'x;
    reg_write(2'd0, {7'b0, 1'b1, d, ra, 1'b0, sa});
    cnt = 0;
    while (busy) begin
      cnt++;
      if (poke && cnt == 40) begin
        reg_we = 1'b1; reg_idx = 2'd0; reg_wdata = 32'h01AA_5511;
      end
      if (poke && cnt == 41) reg_we = 1'b0;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    nbytes = (nb >= 3) ? 3 : nb + 1;
    check(cnt == exp_cycles(hi, lo, nb), "R10", "busy cycles", cnt, exp_cycles(hi, lo, nb));
    reg_read(2'd0, rd);
    check(rd[24] == 1'b0, "R2", "start flag cleared", rd[24], 0);
    check(rd[25] == (nb < 3), "R6", "error flag", rd[25], (nb < 3));
    check(rd[23:0] == {d, ra, 1'b0, sa}, "R7", "fields kept", rd[23:0], {d, ra, 1'b0, sa});
    check(starts == 1 && stops == 1, "R5", "start+stop count", starts * 16 + stops, 17);
    check(bytec == nbytes, "R3", "bytes on bus", bytec, nbytes);
    for (int k = 0; k < nbytes; k++)
      check(cap[k] === exp_byte(k, sa, ra, d), "R3", "byte value", cap[k], exp_byte(k, sa, ra, d));
    check(hmin == hi + 5 && hmax == hi + 5, "R4", "high phase", hmin * 1000 + hmax, (hi + 5) * 1001);
    check(lmin == lo + 7 && lmax == lo + 7, "R4", "low phase", lmin * 1000 + lmax, (lo + 7) * 1001);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all R): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] rd;
    void'($urandom(32'd4711));
    rst_n = 1'b0; reg_we = 1'b0; reg_idx = 2'd0; reg_wdata = '0;
    nack_at = 3; hmin = 0; hmax = 0; lmin = 0; lmax = 0; starts = 0; stops = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    check(!scl_oe && !sda_oe, "R9", "lines released", {scl_oe, sda_oe}, 0);
    check(!busy, "R9", "busy low", busy, 0);
    reg_read(2'd0, rd); check(rd == 32'h0, "R9", "command word", rd, 0);
    reg_read(2'd1, rd); check(rd == 32'h0000_190F, "R9", "clock word", rd, 32'h190F);
    reg_read(2'd2, rd); check(rd == 32'h0, "R9", "mode word", rd, 0);

    // R8: mode word mask, index 3
    reg_write(2'd2, 32'hFFFF_FFFF);
    reg_read(2'd2, rd); check(rd == 32'h0000_005B, "R8", "mode mask", rd, 32'h5B);
    reg_read(2'd3, rd); check(rd == 32'h0, "R8", "index 3", rd, 0);

    // R4: clock word full readback
    reg_write(2'd1, 32'hA5C3_0B06);
    reg_read(2'd1, rd); check(rd == 32'hA5C3_0B06, "R4", "clock readback", rd, 32'hA5C30B06);

    // R1 / R2: field layout, no start without bit 24
    reg_write(2'd0, 32'hFEFF_FFFF);
    reg_read(2'd0, rd); check(rd == 32'h00FF_FF7F, "R1", "command layout", rd, 32'h00FFFF7F);
    repeat (3) @(negedge clk);
    check(!busy && !scl_oe, "R2", "no start without flag", {busy, scl_oe}, 0);

    // directed frames (mode word still all ones: R8 no effect)
    run_xfer(7'h2D, 8'h5A, 8'hC3, 6, 11, 3, 1'b0);
    run_xfer(7'h7F, 8'hFF, 8'hFF, 0, 0, 3, 1'b0);
    run_xfer(7'h00, 8'h00, 8'h00, 1, 2, 3, 1'b0);
    run_xfer(7'h12, 8'h34, 8'h56, 3, 5, 0, 1'b0);
    repeat (20) @(negedge clk);
    reg_read(2'd0, rd); check(rd[25] == 1'b1, "R6", "error stays set", rd[25], 1);
    run_xfer(7'h21, 8'h43, 8'h65, 2, 4, 1, 1'b0);
    run_xfer(7'h55, 8'hAA, 8'h0F, 4, 3, 2, 1'b0);
    run_xfer(7'h3C, 8'h81, 8'h7E, 5, 8, 3, 1'b1);   // R7: write during frame ignored
    check(starts == 1, "R7", "no restart", starts, 1);

    // random frames
    for (int n = 0; n < 12; n++) begin
      int x;
      x = $urandom_range(0, 5);
      run_xfer(7'($urandom), 8'($urandom), 8'($urandom),
               $urandom_range(0, 20), $urandom_range(0, 30), (x > 3) ? 3 : x, n[0]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule